// File: doc/BRIEF.md
# Tag-Presence Power Gate

This block decides when the front end of a half-duplex low-frequency tag reader receives power. With no tag nearby, a slow duty clock turns the front end on for part of each sleep period only. Each read phase of the reader's charge/read cycle, the block counts the bit-sampling strobes that the demodulator produces. Eight strobes in one read phase show that a tag is answering, and they fire a fixed-width one-shot pulse.

On the read-to-charge transition of the phase signal, the block captures the state of the one-shot into a tag-present flag. While that flag is set, the power enable stays on continuously. A read phase without enough strobes captures a low flag, and power falls back to the duty clock. All durations are parameters counted in system clock cycles, so short values can be used for simulation and long ones for silicon.

Top module: `presence_power_gate`

## Requirements
- R1: After reset the duty clock is high for DUTY_HI_CYC cycles, then low for DUTY_LO_CYC cycles, and it repeats with period DUTY_HI_CYC+DUTY_LO_CYC. With the flag clear, `pwr_en_o` follows it.
- R2: During a read phase (`read_phase_i` = 1), each rising edge of `strobe_i` adds one to a 4-bit counter. The edge that brings the count to STROBE_TARGET (8) fires the one-shot. Fewer edges do not fire it.
- R3: Strobes while `read_phase_i` = 0 (charge phase) are not counted and cannot fire the one-shot.
- R4: The counter clears and re-arms on the 0→1 transition of `read_phase_i`, so strobes from different read phases never add up.
- R5: After it fires, the counter is disabled until the next read phase starts, so extra strobes in the same read phase cause no second firing.
- R6: The one-shot is high for exactly PULSE_CYC cycles, starting on the edge that fires it. A capture that happens while it is still high sets the flag.
- R7: On each 1→0 transition of `read_phase_i`, the flag takes the one-shot state. It holds that value until the next such transition. A read phase without a firing releases continuous power.
- R8: `pwr_en_o` is high exactly when the tag-present flag or the duty clock is high.
- R9: Synchronous reset (`rst_i` = 1) clears the flag, the counter and the one-shot, and restarts the duty clock at the start of its high window.
- R10: If the one-shot has expired before the read phase ends, the capture clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| read_phase_i | input | 1 | Charge/read phase signal: 1 = read phase, 0 = charge phase |
| strobe_i | input | 1 | Bit-sampling strobe from the demodulator; rising edges are counted |
| pwr_en_o | output | 1 | Power enable for the reader front end |

## Verification
The duty clock is decoded from its phase counter without extra delay, so the bench predicts the duty level from the number of clock edges since reset and compares on each falling clock edge. A flag change first shows at `pwr_en_o` on the falling clock edge right after the edge where the phase signal was seen low for the first time. The bench waits until the predicted duty level is low before it samples, so a set flag cannot hide behind the duty window. The one-shot width is tested on both sides of its boundary. One read phase ends in the 80th cycle after the firing edge (m = 79, last cycle the one-shot is high), and the other ends one cycle later, when it has just expired.

// File: rtl/pgate_pkg.sv
`timescale 1ns/1ps
package pgate_pkg;

    // Level transitions of one synchronous input.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Observable state of the presence detector.
    typedef struct packed {
        logic fire;   // counter reached the target on this edge
        logic armed;  // counting still allowed in this read phase
        logic pulse;  // one-shot window active
    } presence_t;

    // Index of each edge detector in the generated bank.
    localparam int unsigned EDGE_PHASE  = 0;
    localparam int unsigned EDGE_STROBE = 1;
    localparam int unsigned EDGE_COUNT  = 2;

    // Bits needed to hold the value n.
    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pgate_edge.sv
`timescale 1ns/1ps
module pgate_edge
    import pgate_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  sig_i,
    output edge_t edge_o
);

    logic level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) level_q <= 1'b0;
        else       level_q <= sig_i;
    end

    always_comb begin
        edge_o.rise = sig_i & ~level_q;
        edge_o.fall = ~sig_i & level_q;
    end

endmodule

// File: rtl/pgate_duty_clock.sv
`timescale 1ns/1ps
module pgate_duty_clock
    import pgate_pkg::*;
#(
    parameter int unsigned HI_CYC = 200_000,
    parameter int unsigned LO_CYC = 300_000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic duty_o
);

    localparam int unsigned PERIOD = HI_CYC + LO_CYC;
    localparam int unsigned PH_W   = width_for(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] PH_HI   = PH_W'(HI_CYC);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                   phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                         phase_q <= phase_q + 1'b1;
    end

    // High window occupies the first HI_CYC positions of the period.
    assign duty_o = (phase_q < PH_HI);

endmodule

// File: rtl/pgate_presence_detect.sv
`timescale 1ns/1ps
module pgate_presence_detect
    import pgate_pkg::*;
#(
    parameter int unsigned TARGET    = 8,
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned PULSE_CYC = 25_000
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      read_i,       // level: read phase active
    input  logic      read_start_i, // first cycle of a read phase
    input  logic      strobe_up_i,  // rising edge of sampling strobe
    output presence_t det_o
);

    localparam int unsigned PW = width_for(PULSE_CYC);
    localparam logic [CNT_W-1:0] CNT_TGT  = CNT_W'(TARGET);
    localparam logic [PW-1:0]    PULSE_LD = PW'(PULSE_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             armed_q;
    logic             count_en;
    logic             fire;
    logic [PW-1:0]    pulse_q;

    assign cnt_nx   = cnt_q + 1'b1;
    // A strobe coinciding with the read-phase start is dropped: the clear wins.
    assign count_en = read_i & ~read_start_i & strobe_up_i & armed_q;
    assign fire     = count_en & (cnt_nx == CNT_TGT);

    // Self-disabling strobe counter.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (read_start_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (count_en) begin
            cnt_q <= cnt_nx;
            if (cnt_nx == CNT_TGT) armed_q <= 1'b0;
        end
    end

    // Fixed-width one-shot, reloaded on every firing.
    always_ff @(posedge clk_i) begin
        if (rst_i)              pulse_q <= '0;
        else if (fire)          pulse_q <= PULSE_LD;
        else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end

    always_comb begin
        det_o.fire  = fire;
        det_o.armed = armed_q;
        det_o.pulse = (pulse_q != '0);
    end

endmodule

// File: rtl/pgate_flag_latch.sv
`timescale 1ns/1ps
module pgate_flag_latch (
    input  logic clk_i,
    input  logic rst_i,
    input  logic capture_i,
    input  logic pulse_i,
    output logic flag_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)          flag_o <= 1'b0;
        else if (capture_i) flag_o <= pulse_i;
    end

endmodule

// File: rtl/presence_power_gate.sv
`timescale 1ns/1ps
module presence_power_gate
    import pgate_pkg::*;
#(
    parameter int unsigned DUTY_HI_CYC   = 200_000,
    parameter int unsigned DUTY_LO_CYC   = 300_000,
    parameter int unsigned PULSE_CYC     = 25_000,
    parameter int unsigned STROBE_TARGET = 8,
    parameter int unsigned STROBE_CNT_W  = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic read_phase_i,
    input  logic strobe_i,
    output logic pwr_en_o
);

    logic [EDGE_COUNT-1:0] raw_in;
    edge_t                 edges [EDGE_COUNT];
    edge_t                 ph_edge;
    edge_t                 str_edge;
    presence_t             det;
    logic                  duty;
    logic                  tag_flag;

    assign raw_in[EDGE_PHASE]  = read_phase_i;
    assign raw_in[EDGE_STROBE] = strobe_i;

    for (genvar g = 0; g < EDGE_COUNT; g++) begin : g_edge
        pgate_edge u_edge (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .sig_i  (raw_in[g]),
            .edge_o (edges[g])
        );
    end

    assign ph_edge  = edges[EDGE_PHASE];
    assign str_edge = edges[EDGE_STROBE];

    pgate_duty_clock #(
        .HI_CYC (DUTY_HI_CYC),
        .LO_CYC (DUTY_LO_CYC)
    ) u_duty (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .duty_o (duty)
    );

    pgate_presence_detect #(
        .TARGET    (STROBE_TARGET),
        .CNT_W     (STROBE_CNT_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_detect (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .read_i       (read_phase_i),
        .read_start_i (ph_edge.rise),
        .strobe_up_i  (str_edge.rise),
        .det_o        (det)
    );

    // Capture on the read-to-charge transition.
    pgate_flag_latch u_flag (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_i (ph_edge.fall),
        .pulse_i   (det.pulse),
        .flag_o    (tag_flag)
    );

    assign pwr_en_o = tag_flag | duty;

endmodule

// File: rtl/presence_power_gate_chk.sv
`timescale 1ns/1ps
module presence_power_gate_chk
    import pgate_pkg::*;
#(
    parameter int unsigned DUTY_HI_CYC = 200_000,
    parameter int unsigned DUTY_LO_CYC = 300_000
) (
    input logic      clk_i,
    input logic      rst_i,
    input logic      read_phase_i,
    input logic      pwr_en_o,
    input edge_t     ph_edge,
    input edge_t     str_edge,
    input presence_t det,
    input logic      duty,
    input logic      flag
);

    // Run lengths of the duty levels, counted in the checker.
    logic [31:0] hi_run;
    logic [31:0] lo_run;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= duty ? hi_run + 1 : '0;
            lo_run <= duty ? '0 : lo_run + 1;
        end
    end

    a_r1_hi_window: assert property (@(posedge clk_i) disable iff (rst_i)
        duty |-> (hi_run < DUTY_HI_CYC));

    a_r1_lo_window: assert property (@(posedge clk_i) disable iff (rst_i)
        !duty |-> (lo_run < DUTY_LO_CYC));

    a_r2_fire_on_strobe: assert property (@(posedge clk_i) disable iff (rst_i)
        det.fire |-> (read_phase_i && str_edge.rise));

    a_r3_no_fire_charge: assert property (@(posedge clk_i) disable iff (rst_i)
        !read_phase_i |-> !det.fire);

    a_r4_rearm: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_edge.rise |=> det.armed);

    a_r5_disarm: assert property (@(posedge clk_i) disable iff (rst_i)
        det.fire |=> (!det.armed && !det.fire));

    a_r6_pulse_start: assert property (@(posedge clk_i) disable iff (rst_i)
        det.fire |=> det.pulse);

    a_r7_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_edge.fall |=> (flag == $past(det.pulse)));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ph_edge.fall |=> $stable(flag));

    a_r8_on: assert property (@(posedge clk_i) disable iff (rst_i)
        (duty || flag) |-> pwr_en_o);

    a_r8_off: assert property (@(posedge clk_i) disable iff (rst_i)
        (!duty && !flag) |-> !pwr_en_o);

endmodule

bind presence_power_gate presence_power_gate_chk #(
    .DUTY_HI_CYC (DUTY_HI_CYC),
    .DUTY_LO_CYC (DUTY_LO_CYC)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .read_phase_i (read_phase_i),
    .pwr_en_o     (pwr_en_o),
    .ph_edge      (ph_edge),
    .str_edge     (str_edge),
    .det          (det),
    .duty         (duty),
    .flag         (tag_flag)
);

// File: tb/test_presence_power_gate.sv
`timescale 1ns/1ps
module test_presence_power_gate;

    localparam int HI     = 40;
    localparam int LO     = 60;
    localparam int PERIOD = HI + LO;
    localparam int PULSE  = 80;
    localparam int CHG    = 40;
    localparam int READ   = 60;

    // Row: [15:12] requirement, [11:8] read strobes, [7:4] charge strobes, [0] expected flag
    localparam logic [15:0] VEC [10] = '{
        16'h2801,   // R2: eight strobes in read -> present
        16'h7000,   // R7: silent read -> released
        16'h2700,   // R2: seven strobes -> not enough
        16'h3030,   // R3: charge strobes after an armed count of 7
        16'h4400,   // R4: four strobes
        16'h4400,   // R4: four more in the next read do not add up
        16'h3080,   // R3: eight charge strobes ignored
        16'h5C01,   // R5: twelve strobes, single firing
        16'h2901,   // R2: nine strobes -> present
        16'h7000    // R7: released again
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic read_phase = 1'b0;
    logic strobe = 1'b0;
    logic pwr_en;

    int k = 0;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    presence_power_gate #(
        .DUTY_HI_CYC   (HI),
        .DUTY_LO_CYC   (LO),
        .PULSE_CYC     (PULSE),
        .STROBE_TARGET (8),
        .STROBE_CNT_W  (4)
    ) i_presence_power_gate (
        .clk_i        (clk),
        .rst_i        (rst),
        .read_phase_i (read_phase),
        .strobe_i     (strobe),
        .pwr_en_o     (pwr_en)
    );

    // Edges since reset release, the time base of R1.
    always @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    function automatic bit duty_exp();
        return (k % PERIOD) < HI;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: pwr_en=%0b expected %0b (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic one_strobe();
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // End the read phase, then sample once at once and once in a duty-low slot.
    task automatic end_read(input string req, input logic exp_flag);
        read_phase = 1'b0;
        @(negedge clk);
        chk(req, pwr_en, exp_flag | duty_exp());
        while (duty_exp()) @(negedge clk);
        chk(req, pwr_en, exp_flag);
    endtask

    task automatic run_row(input int rn, input int cn, input logic exp_flag, input string req);
        repeat (CHG - 4 * cn) @(negedge clk);
        for (int i = 0; i < cn; i++) one_strobe();
        read_phase = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < rn; i++) one_strobe();
        repeat (READ - 2 - 4 * rn) @(negedge clk);
        end_read(req, exp_flag);
    endtask

    // Eight strobes, then 'tail' idle cycles before the read phase ends.
    task automatic fire_then_wait(input int tail, input logic exp_flag, input string req);
        repeat (CHG) @(negedge clk);
        read_phase = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) one_strobe();
        repeat (tail) @(negedge clk);
        end_read(req, exp_flag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: during reset the duty clock sits at the start of its high window
        chk("R9", pwr_en, 1'b1);
        rst = 1'b0;

        // R1: duty clock alone, no tag
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            chk("R1", pwr_en, duty_exp());
        end

        // Table walk: R2, R3, R4, R5, R7, R8
        for (int r = 0; r < 10; r++) begin
            logic [15:0] v;
            v = VEC[r];
            run_row(int'(v[11:8]), int'(v[7:4]), v[0], $sformatf("R%0d", v[15:12]));
        end

        // R6: capture in the last cycle of the one-shot window
        fire_then_wait(76, 1'b1, "R6");
        // R10: capture one cycle after the one-shot expired
        fire_then_wait(77, 1'b0, "R10");

        // R9: reset with the flag set clears it
        fire_then_wait(20, 1'b1, "R8");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9", pwr_en, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        while (duty_exp()) @(negedge clk);
        chk("R9", pwr_en, 1'b0);

        finish_run();
    end

    initial begin
        repeat (100_000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

endmodule